// File: doc/BRIEF.md
# Serial EEPROM Transaction Sequencer

This block sits above a two-wire serial bit engine and runs whole memory transactions: a presence probe, a multi-byte write, and a random read. A single request carries the transaction kind, a 7-bit device address, a memory address of zero up to `MAX_ALEN` bytes, a byte count of up to `MAX_LEN`, and a turnaround choice. From that request the block emits one bus command at a time to the bit engine: start condition, stop condition, write a byte, or read a byte. It then waits for the engine's completion pulse and examines the acknowledge bit that comes back.

Write data is taken from a valid/ready byte stream, one byte for each data phase. Read data leaves on a second valid/ready byte stream, and the next byte is not fetched from the bus until the current one has been taken. When the transaction is over, the block raises a one-cycle result with one of three outcome codes and a count of data bytes the device refused.

A build-time mask can fold the memory-address bits that lie above the selected address length into the low device-address bits. With this, a small memory that uses device-address bits as page bits can be reached as several 256-byte devices.

Top module: `i2c_eeprom_seq`

## Requirements
- R1: A probe (kind 0) issues start, the device address shifted left by one with bit 0 = 0, then stop. The result is code 0 when that byte is acknowledged and code 1 when it is not.
- R2: Memory address bytes are written most significant byte first, exactly `req_alen` of them, after the device address byte.
- R3: A read (kind 2) with `req_alen` > 0 first writes the device address with bit 0 = 0, then the address bytes. It then issues stop followed by start when `req_rstart` = 0, or start alone when `req_rstart` = 1, and then writes the device address with bit 0 = 1.
- R4: A read with `req_alen` = 0 issues start and then goes directly to the device address with bit 0 = 1, with no pointer-setting write.
- R5: A read fetches `req_len` bytes with read-byte commands. `cmd_nack` is 1 only on the last one, and the bytes leave on the read stream in bus order.
- R6: A device address byte that is not acknowledged, whether in the write phase or the read phase, is followed by stop and result code 1, with no further byte commands.
- R7: A memory address byte that is not acknowledged is followed by stop and result code 2, with no data bytes.
- R8: In a write (kind 1), a refused data byte does not end the transfer. Every one of the `req_len` data bytes is sent, and `res_fails` reports how many were refused, with code 0.
- R9: The device address actually sent is `req_chip | ((req_addr >> 8*req_alen) & OVF_MASK)`.
- R10: Every transaction's last command is a stop. `res_valid` is a single-cycle pulse after that stop completes. `req_ready` is high only while idle, and no command or stream handshake is offered while idle.
- R11: A command on `cmd_valid`/`cmd_op`/`cmd_byte`/`cmd_nack` is held unchanged until the cycle `eng_done` is high. The `cmd_op` encoding is 0 start, 1 stop, 2 write byte, 3 read byte.
- R12: While `rd_valid` is high and `rd_ready` is low, `rd_valid` and `rd_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted |
| req_kind | input | 2 | 0 probe, 1 write, 2 read |
| req_chip | input | 7 | Device address |
| req_addr | input | 8*MAX_ALEN | Memory address |
| req_alen | input | clog2(MAX_ALEN+1) | Memory address length in bytes |
| req_len | input | clog2(MAX_LEN+1) | Data byte count |
| req_rstart | input | 1 | Read turnaround: 1 repeated start, 0 stop then start |
| wr_valid | input | 1 | Write data byte present |
| wr_ready | output | 1 | Write data byte taken |
| wr_data | input | 8 | Write data byte |
| rd_valid | output | 1 | Read data byte present |
| rd_ready | input | 1 | Read data byte taken |
| rd_data | output | 8 | Read data byte |
| cmd_valid | output | 1 | Command to bit engine |
| cmd_op | output | 2 | 0 start, 1 stop, 2 write byte, 3 read byte |
| cmd_byte | output | 8 | Byte for a write command |
| cmd_nack | output | 1 | Refuse the byte on a read command |
| eng_done | input | 1 | Command finished (one cycle) |
| eng_nack | input | 1 | Written byte was not acknowledged |
| eng_rdata | input | 8 | Byte returned by a read command |
| res_valid | output | 1 | Result pulse |
| res_code | output | 2 | 0 done, 1 no device, 2 address refused |
| res_fails | output | clog2(MAX_LEN+1) | Refused data bytes in a write |

## Verification
A wrong state transition here shows up at the command port within one engine round trip: an extra or missing address byte, a turnaround stop where only a start belongs, or a NACK on the wrong read byte. Each of these appears as a mismatch against the command sequence the bench predicts from the request and the acknowledge pattern it feeds back. A broken byte counter or fold shows up the same way, in the command count or in the device address byte. A broken failure count shows up in `res_fails` at the result pulse. Random read backpressure exposes a read stream that drops or repeats bytes, because the byte order on the stream is compared against what the engine returned.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } bus_op_e;

    typedef enum logic [1:0] {
        XF_PROBE = 2'd0,
        XF_WRITE = 2'd1,
        XF_READ  = 2'd2
    } xfer_kind_e;

    typedef enum logic [1:0] {
        RC_OK    = 2'd0,
        RC_NODEV = 2'd1,
        RC_ADDR  = 2'd2
    } res_code_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_START,
        S_CHIP_W,
        S_ADDR,
        S_TURN_STOP,
        S_TURN_START,
        S_CHIP_R,
        S_RD_BYTE,
        S_RD_PUSH,
        S_WR_FETCH,
        S_WR_BYTE,
        S_STOP,
        S_REPORT
    } seq_state_e;

    // Page bits above the used address length land in the low device bits.
    function automatic logic [6:0] fold_chip(input logic [6:0] chip,
                                             input logic [31:0] addr,
                                             input logic [2:0] alen,
                                             input logic [6:0] mask);
        return chip | (7'(addr >> {alen, 3'b000}) & mask);
    endfunction

endpackage

// File: rtl/i2c_seq_addr_pick.sv
module i2c_seq_addr_pick #(
    parameter  int MAX_ALEN = 2,
    localparam int ADDR_W   = 8 * MAX_ALEN,
    localparam int ALEN_W   = $clog2(MAX_ALEN + 1)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ALEN_W-1:0] left,
    output logic [7:0]        byte_out
);
    logic [7:0] lanes [MAX_ALEN];

    for (genvar g = 0; g < MAX_ALEN; g++) begin : g_lane
        assign lanes[g] = addr[g*8 +: 8];
    end

    // 'left' counts bytes still to send, so the top byte goes first.
    always_comb begin
        byte_out = 8'h00;
        for (int i = 0; i < MAX_ALEN; i++) begin
            if (left == ALEN_W'(i + 1)) byte_out = lanes[i];
        end
    end
endmodule

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm
    import i2c_seq_pkg::*;
#(
    parameter  int         MAX_ALEN = 2,
    parameter  int         MAX_LEN  = 16,
    parameter  logic [6:0] OVF_MASK = 7'h00,
    localparam int         ADDR_W   = 8 * MAX_ALEN,
    localparam int         ALEN_W   = $clog2(MAX_ALEN + 1),
    localparam int         LEN_W    = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [6:0]        req_chip,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ALEN_W-1:0] req_alen,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_rstart,
    input  logic              eng_done,
    input  logic              eng_nack,
    input  logic [7:0]        eng_rdata,
    input  logic              wr_valid,
    input  logic [7:0]        wr_data,
    input  logic              rd_ready,
    output seq_state_e        state,
    output logic [6:0]        chip_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [ALEN_W-1:0] left_q,
    output logic              last_rd,
    output logic [7:0]        dbyte_q,
    output res_code_e         code_q,
    output logic [LEN_W-1:0]  fails_q
);
    xfer_kind_e        kind_q;
    logic [ALEN_W-1:0] alen_q;
    logic [LEN_W-1:0]  cnt_q;
    logic              rstart_q;
    seq_state_e        after_addr;

    assign last_rd = (cnt_q == LEN_W'(1));

    always_comb begin
        if (kind_q == XF_READ)
            after_addr = rstart_q ? S_TURN_START : S_TURN_STOP;
        else
            after_addr = (cnt_q == '0) ? S_STOP : S_WR_FETCH;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            kind_q   <= XF_PROBE;
            chip_q   <= '0;
            addr_q   <= '0;
            alen_q   <= '0;
            left_q   <= '0;
            cnt_q    <= '0;
            rstart_q <= 1'b0;
            dbyte_q  <= '0;
            code_q   <= RC_OK;
            fails_q  <= '0;
        end else begin
            case (state)
                S_IDLE: if (req_valid) begin
                    kind_q   <= xfer_kind_e'(req_kind);
                    chip_q   <= fold_chip(req_chip, 32'(req_addr), 3'(req_alen), OVF_MASK);
                    addr_q   <= req_addr;
                    alen_q   <= req_alen;
                    left_q   <= req_alen;
                    cnt_q    <= req_len;
                    rstart_q <= req_rstart;
                    code_q   <= RC_OK;
                    fails_q  <= '0;
                    state    <= S_START;
                end
                S_START: if (eng_done)
                    state <= (kind_q == XF_READ && alen_q == '0) ? S_CHIP_R : S_CHIP_W;
                S_CHIP_W: if (eng_done) begin
                    if (eng_nack) begin
                        code_q <= RC_NODEV;
                        state  <= S_STOP;
                    end else if (kind_q == XF_PROBE) begin
                        state <= S_STOP;
                    end else if (left_q != '0) begin
                        state <= S_ADDR;
                    end else begin
                        state <= after_addr;
                    end
                end
                S_ADDR: if (eng_done) begin
                    if (eng_nack) begin
                        code_q <= RC_ADDR;
                        state  <= S_STOP;
                    end else begin
                        left_q <= left_q - ALEN_W'(1);
                        if (left_q == ALEN_W'(1)) state <= after_addr;
                    end
                end
                S_TURN_STOP:  if (eng_done) state <= S_TURN_START;
                S_TURN_START: if (eng_done) state <= S_CHIP_R;
                S_CHIP_R: if (eng_done) begin
                    if (eng_nack) begin
                        code_q <= RC_NODEV;
                        state  <= S_STOP;
                    end else begin
                        state <= (cnt_q == '0) ? S_STOP : S_RD_BYTE;
                    end
                end
                S_RD_BYTE: if (eng_done) begin
                    dbyte_q <= eng_rdata;
                    state   <= S_RD_PUSH;
                end
                S_RD_PUSH: if (rd_ready) begin
                    cnt_q <= cnt_q - LEN_W'(1);
                    state <= last_rd ? S_STOP : S_RD_BYTE;
                end
                S_WR_FETCH: if (wr_valid) begin
                    dbyte_q <= wr_data;
                    state   <= S_WR_BYTE;
                end
                S_WR_BYTE: if (eng_done) begin
                    if (eng_nack) fails_q <= fails_q + LEN_W'(1);
                    cnt_q <= cnt_q - LEN_W'(1);
                    state <= last_rd ? S_STOP : S_WR_FETCH;
                end
                S_STOP:   if (eng_done) state <= S_REPORT;
                S_REPORT: state <= S_IDLE;
                default:  state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2c_seq_cmd_enc.sv
module i2c_seq_cmd_enc
    import i2c_seq_pkg::*;
(
    input  seq_state_e  state,
    input  logic [6:0]  chip_q,
    input  logic [7:0]  addr_byte,
    input  logic [7:0]  dbyte_q,
    input  logic        last_rd,
    output logic        cmd_valid,
    output logic [1:0]  cmd_op,
    output logic [7:0]  cmd_byte,
    output logic        cmd_nack,
    output logic        req_ready,
    output logic        wr_ready,
    output logic        rd_valid,
    output logic        res_valid
);
    bus_op_e op;

    always_comb begin
        cmd_valid = 1'b1;
        op        = OP_WRITE;
        cmd_byte  = 8'h00;
        case (state)
            S_START, S_TURN_START: op = OP_START;
            S_STOP,  S_TURN_STOP:  op = OP_STOP;
            S_CHIP_W:  cmd_byte = {chip_q, 1'b0};
            S_CHIP_R:  cmd_byte = {chip_q, 1'b1};
            S_ADDR:    cmd_byte = addr_byte;
            S_WR_BYTE: cmd_byte = dbyte_q;
            S_RD_BYTE: op = OP_READ;
            default:   cmd_valid = 1'b0;
        endcase
    end

    assign cmd_op    = op;
    assign cmd_nack  = (state == S_RD_BYTE) && last_rd;
    assign req_ready = (state == S_IDLE);
    assign wr_ready  = (state == S_WR_FETCH);
    assign rd_valid  = (state == S_RD_PUSH);
    assign res_valid = (state == S_REPORT);
endmodule

// File: rtl/i2c_eeprom_seq.sv
module i2c_eeprom_seq
    import i2c_seq_pkg::*;
#(
    parameter  int         MAX_ALEN = 2,
    parameter  int         MAX_LEN  = 16,
    parameter  logic [6:0] OVF_MASK = 7'h00,
    localparam int         ADDR_W   = 8 * MAX_ALEN,
    localparam int         ALEN_W   = $clog2(MAX_ALEN + 1),
    localparam int         LEN_W    = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [6:0]        req_chip,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ALEN_W-1:0] req_alen,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_rstart,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [7:0]        wr_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [7:0]        rd_data,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [7:0]        cmd_byte,
    output logic              cmd_nack,
    input  logic              eng_done,
    input  logic              eng_nack,
    input  logic [7:0]        eng_rdata,
    output logic              res_valid,
    output logic [1:0]        res_code,
    output logic [LEN_W-1:0]  res_fails
);
    seq_state_e        state;
    logic [6:0]        chip_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ALEN_W-1:0] left_q;
    logic              last_rd;
    logic [7:0]        dbyte_q;
    logic [7:0]        addr_byte;
    res_code_e         code_q;

    i2c_seq_fsm #(.MAX_ALEN(MAX_ALEN), .MAX_LEN(MAX_LEN), .OVF_MASK(OVF_MASK)) u_fsm (
        .clk, .rst, .req_valid, .req_kind, .req_chip, .req_addr, .req_alen,
        .req_len, .req_rstart, .eng_done, .eng_nack, .eng_rdata, .wr_valid,
        .wr_data, .rd_ready, .state, .chip_q, .addr_q, .left_q, .last_rd,
        .dbyte_q, .code_q, .fails_q(res_fails)
    );

    i2c_seq_addr_pick #(.MAX_ALEN(MAX_ALEN)) u_pick (
        .addr(addr_q), .left(left_q), .byte_out(addr_byte)
    );

    i2c_seq_cmd_enc u_enc (
        .state, .chip_q, .addr_byte, .dbyte_q, .last_rd, .cmd_valid, .cmd_op,
        .cmd_byte, .cmd_nack, .req_ready, .wr_ready, .rd_valid, .res_valid
    );

    assign rd_data  = dbyte_q;
    assign res_code = code_q;
endmodule

// File: rtl/i2c_seq_chk.sv
module i2c_seq_chk #(
    parameter int LEN_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             req_ready,
    input logic             wr_ready,
    input logic             rd_valid,
    input logic             rd_ready,
    input logic [7:0]       rd_data,
    input logic             cmd_valid,
    input logic [1:0]       cmd_op,
    input logic [7:0]       cmd_byte,
    input logic             cmd_nack,
    input logic             eng_done,
    input logic             res_valid,
    input logic [1:0]       res_code,
    input logic [LEN_W-1:0] res_fails
);
    logic [1:0] last_done_op;

    always_ff @(posedge clk) begin
        if (rst)                        last_done_op <= 2'd1;
        else if (eng_done && cmd_valid) last_done_op <= cmd_op;
    end

    p_cmd_hold_r11: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !eng_done |=> cmd_valid && $stable(cmd_op) && $stable(cmd_byte) && $stable(cmd_nack));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !cmd_valid && !rd_valid && !wr_ready && !res_valid);

    p_stop_last_r10: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> last_done_op == 2'd1);

    p_res_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid && req_ready);

    p_rd_hold_r12: assert property (@(posedge clk) disable iff (rst)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

    p_nodev_nofail_r6: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_code == 2'd1 |-> res_fails == '0);
endmodule

bind i2c_eeprom_seq i2c_seq_chk #(.LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready), .wr_ready(wr_ready),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
    .cmd_nack(cmd_nack), .eng_done(eng_done), .res_valid(res_valid),
    .res_code(res_code), .res_fails(res_fails)
);

// File: tb/i2c_eeprom_seq_test.sv
module i2c_eeprom_seq_test;
    localparam logic [6:0] OVF = 7'h03;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_rstart = 1'b0;
    logic [1:0] req_kind = '0, req_alen = '0;
    logic [6:0] req_chip = '0;
    logic [15:0] req_addr = '0;
    logic [4:0] req_len = '0;
    logic wr_valid = 1'b0, rd_ready = 1'b0, eng_done = 1'b0, eng_nack = 1'b0;
    logic [7:0] wr_data = '0, eng_rdata = '0;
    logic req_ready, wr_ready, rd_valid, cmd_valid, cmd_nack, res_valid;
    logic [7:0] rd_data, cmd_byte;
    logic [1:0] cmd_op, res_code;
    logic [4:0] res_fails;

    always #4 clk = ~clk;

    i2c_eeprom_seq #(.MAX_ALEN(2), .MAX_LEN(16), .OVF_MASK(OVF)) uut (
        .clk, .rst, .req_valid, .req_ready, .req_kind, .req_chip, .req_addr,
        .req_alen, .req_len, .req_rstart, .wr_valid, .wr_ready, .wr_data,
        .rd_valid, .rd_ready, .rd_data, .cmd_valid, .cmd_op, .cmd_byte,
        .cmd_nack, .eng_done, .eng_nack, .eng_rdata, .res_valid, .res_code,
        .res_fails
    );

    int checks = 0, errors = 0;
    logic [10:0] log_q [64];
    logic [10:0] exp_q [64];
    int log_n, exp_n;
    logic [7:0] wr_buf [16];
    logic [7:0] rd_got [16];
    logic [7:0] exp_rd [16];
    int wr_len = 0, wr_ptr = 0, rd_n = 0, exp_rd_n = 0;
    logic [63:0] wn = '0;
    int wcmd_i = 0, rcmd_i = 0, hold_bad = 0, res_cnt = 0, lat = 0, exp_fails = 0;
    logic [7:0] rseed = '0, pdata = '0;
    logic pnack = 1'b0, busy = 1'b0;
    logic [10:0] held = '0;
    logic [1:0] got_code = '0, exp_code = '0;
    logic [4:0] got_fails = '0;

    function automatic logic [10:0] ent(input logic [1:0] op, input logic [7:0] b, input logic nk);
        return {op, b, nk};
    endfunction

    function automatic logic [7:0] rdpat(input int i);
        return 8'(i * 29 + 91) ^ rseed;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic push(input logic [10:0] e);
        if (exp_n < 64) exp_q[exp_n] = e;
        exp_n++;
    endtask

    // Expected command stream, result and read data straight from the requirements.
    task automatic build(input logic [1:0] kind, input logic [6:0] chip, input logic [15:0] addr,
                         input logic [1:0] alen, input logic [4:0] len, input bit rs);
        logic [6:0] ce;
        int wi;
        bit dead;
        ce = chip | (7'(32'(addr) >> (8 * alen)) & OVF);   // R9
        exp_n = 0; exp_rd_n = 0; exp_fails = 0; exp_code = 2'd0; wi = 0; dead = 0;
        push(ent(2'd0, 8'h00, 1'b0));
        if (!(kind == 2'd2 && alen == 2'd0)) begin
            push(ent(2'd2, {ce, 1'b0}, 1'b0));
            if (wn[wi]) begin exp_code = 2'd1; dead = 1; end
            wi++;
            if (!dead && kind != 2'd0) begin
                for (int k = int'(alen) - 1; k >= 0; k--) begin
                    if (!dead) begin
                        push(ent(2'd2, 8'(addr >> (8 * k)), 1'b0));   // R2
                        if (wn[wi]) begin exp_code = 2'd2; dead = 1; end
                        wi++;
                    end
                end
            end
            if (!dead && kind == 2'd1) begin
                for (int j = 0; j < int'(len); j++) begin
                    push(ent(2'd2, wr_buf[j], 1'b0));
                    if (wn[wi]) exp_fails++;
                    wi++;
                end
            end
            if (!dead && kind == 2'd2) begin
                if (!rs) push(ent(2'd1, 8'h00, 1'b0));
                push(ent(2'd0, 8'h00, 1'b0));
            end
        end
        if (!dead && kind == 2'd2) begin
            push(ent(2'd2, {ce, 1'b1}, 1'b0));
            if (wn[wi]) begin exp_code = 2'd1; dead = 1; end
            wi++;
            if (!dead) begin
                for (int j = 0; j < int'(len); j++) begin
                    push(ent(2'd3, 8'h00, j == int'(len) - 1));
                    exp_rd[j] = rdpat(j);
                    exp_rd_n++;
                end
            end
        end
        push(ent(2'd1, 8'h00, 1'b0));
    endtask

    // Bit engine, device responses and data streams, all driven at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (eng_done) begin
                    eng_done = 1'b0;
                    busy = 1'b0;
                end else if (busy) begin
                    if (!cmd_valid || {cmd_op, cmd_byte, cmd_nack} != held) hold_bad++;
                    if (lat == 0) begin
                        eng_done = 1'b1;
                        eng_nack = pnack;
                        eng_rdata = pdata;
                    end else lat--;
                end
                if (!busy && cmd_valid) begin
                    busy = 1'b1;
                    lat = int'($urandom % 3);
                    held = {cmd_op, cmd_byte, cmd_nack};
                    pnack = 1'b0;
                    if (log_n < 64)
                        log_q[log_n] = ent(cmd_op, (cmd_op == 2'd2) ? cmd_byte : 8'h00,
                                           (cmd_op == 2'd3) ? cmd_nack : 1'b0);
                    log_n++;
                    if (cmd_op == 2'd2) begin
                        pnack = (wcmd_i < 64) ? wn[wcmd_i] : 1'b0;
                        wcmd_i++;
                    end else if (cmd_op == 2'd3) begin
                        pdata = rdpat(rcmd_i);
                        rcmd_i++;
                    end
                end
                if (wr_ptr < wr_len) begin
                    wr_valid = ($urandom % 4) != 0;
                    wr_data = wr_buf[wr_ptr];
                end else wr_valid = 1'b0;
                if (wr_valid && wr_ready) wr_ptr++;
                rd_ready = ($urandom % 3) != 0;
                if (rd_valid && rd_ready) begin
                    if (rd_n < 16) rd_got[rd_n] = rd_data;
                    rd_n++;
                end
                if (res_valid) begin
                    res_cnt++;
                    got_code = res_code;
                    got_fails = res_fails;
                end
            end
        end
    end

    task automatic run(input logic [1:0] kind, input logic [6:0] chip, input logic [15:0] addr,
                       input logic [1:0] alen, input logic [4:0] len, input bit rs,
                       input logic [63:0] mask, input string tag);
        int t;
        bit same;
        @(negedge clk);
        wn = mask;
        rseed = 8'($urandom);
        for (int j = 0; j < 16; j++) wr_buf[j] = 8'($urandom);
        wr_len = (kind == 2'd1) ? int'(len) : 0;
        wr_ptr = 0; log_n = 0; rd_n = 0; wcmd_i = 0; rcmd_i = 0; hold_bad = 0; res_cnt = 0;
        build(kind, chip, addr, alen, len, rs);
        chk(req_ready == 1'b1, "R10", "ready before request", longint'(req_ready), 1);
        req_kind = kind; req_chip = chip; req_addr = addr; req_alen = alen;
        req_len = len; req_rstart = rs; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        t = 0;
        while (res_cnt == 0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (2) @(negedge clk);
        chk(log_n == exp_n, tag, "command count", log_n, exp_n);
        same = (log_n == exp_n);
        for (int i = 0; i < exp_n && i < 64; i++) begin
            if (same && log_q[i] != exp_q[i]) begin
                same = 0;
                chk(0, tag, $sformatf("command %0d", i), longint'(log_q[i]), longint'(exp_q[i]));
            end
        end
        chk(log_n > 0 && log_q[(log_n - 1) % 64][10:9] == 2'd1, "R10", "final stop",
            longint'(log_q[(log_n + 63) % 64][10:9]), 1);
        chk(res_cnt == 1, "R10", "result pulses", res_cnt, 1);
        chk(got_code == exp_code, (exp_code == 2'd1) ? "R6" : (exp_code == 2'd2) ? "R7" : tag,
            "result code", longint'(got_code), longint'(exp_code));
        chk(hold_bad == 0, "R11", "command hold", hold_bad, 0);
        if (kind == 2'd1)
            chk(int'(got_fails) == exp_fails, "R8", "fail count", longint'(got_fails), exp_fails);
        if (kind == 2'd2) begin
            chk(rd_n == exp_rd_n, "R5/R12", "read byte count", rd_n, exp_rd_n);
            for (int j = 0; j < exp_rd_n && j < rd_n && j < 16; j++)
                if (rd_got[j] != exp_rd[j])
                    chk(0, "R5/R12", $sformatf("read byte %0d", j), longint'(rd_got[j]), longint'(exp_rd[j]));
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10", "reset ready", longint'(req_ready), 1);
        chk(cmd_valid == 1'b0 && rd_valid == 1'b0 && res_valid == 1'b0 && wr_ready == 1'b0,
            "R10", "reset quiet", longint'({cmd_valid, rd_valid, res_valid, wr_ready}), 0);
        run(2'd0, 7'h50, 16'h0000, 2'd0, 5'd0, 1'b0, 64'h0, "R1");
        run(2'd0, 7'h51, 16'h0000, 2'd0, 5'd0, 1'b0, 64'h1, "R1");
        run(2'd1, 7'h50, 16'hA1B2, 2'd2, 5'd4, 1'b0, 64'h0, "R2");
        run(2'd1, 7'h50, 16'h1234, 2'd2, 5'd5, 1'b0, 64'h50, "R8");
        run(2'd1, 7'h50, 16'h1234, 2'd2, 5'd3, 1'b0, 64'h1, "R6");
        run(2'd1, 7'h50, 16'h1234, 2'd2, 5'd3, 1'b0, 64'h4, "R7");
        run(2'd2, 7'h50, 16'hC0DE, 2'd2, 5'd5, 1'b0, 64'h0, "R3");
        run(2'd2, 7'h50, 16'h00EE, 2'd1, 5'd3, 1'b1, 64'h0, "R3");
        run(2'd2, 7'h40, 16'h0000, 2'd0, 5'd4, 1'b0, 64'h0, "R4");
        run(2'd2, 7'h50, 16'h0010, 2'd1, 5'd1, 1'b0, 64'h0, "R5");
        run(2'd1, 7'h50, 16'h0312, 2'd1, 5'd2, 1'b0, 64'h0, "R9");
        run(2'd2, 7'h50, 16'h02AB, 2'd1, 5'd2, 1'b1, 64'h0, "R9");
        run(2'd2, 7'h40, 16'h0000, 2'd0, 5'd3, 1'b0, 64'h1, "R6");
        run(2'd1, 7'h50, 16'h0077, 2'd1, 5'd0, 1'b0, 64'h0, "R8");
        run(2'd2, 7'h50, 16'h1234, 2'd2, 5'd16, 1'b0, 64'h0, "R5");
        for (int n = 0; n < 150; n++) begin
            logic [63:0] m;
            logic [1:0] k;
            m = '0;
            for (int b = 0; b < 64; b++) m[b] = ($urandom % 10) == 0;
            k = 2'($urandom % 3);
            run(k, 7'($urandom), 16'($urandom), 2'($urandom % 3), 5'($urandom % 17),
                1'($urandom), m, (k == 2'd0) ? "R1" : (k == 2'd1) ? "R8" : "R3");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule